// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Timer

This block chooses which of two programmed 3-bit charge-pump current codes drives the loop. The primary code is meant for the settled loop. The secondary, usually larger, code is meant for the interval right after a new output frequency is programmed, so that the loop settles faster. Software programs both codes, an enable, a mode select and a 4-bit timer code through the function latch write port. It starts a fast-settle interval by writing a gain bit of 1 through the feedback-counter latch write port.

There are two modes. In the manual mode the secondary code stays active until software writes the gain bit back to 0. In the timed mode an internal counter counts phase-detector clock strobes. When the programmed timeout expires, the counter clears the stored gain bit by itself and the output falls back to the primary code. The stored gain bit can be read back at all times. A separate power-down input freezes the timer at its load value.

Top module: `fastlock_cp_timer`

## Requirements
- R1: After reset, `cp_code` is 0 and `gain_bit` is 0. The reset state of the function latch has fastlock disabled and both current codes at 0.
- R2: A `fb_wr` pulse stores `fb_gain` into the gain bit. `gain_bit` shows the new value in the cycle after the write. The gain bit only goes from 0 to 1 through such a write.
- R3: A `func_wr` pulse loads the configuration from `func_data`: bit 9 enables fastlock, bit 10 selects the mode (0 manual, 1 timed), bits 14:11 hold the timer code, bits 17:15 hold the primary code and bits 20:18 hold the secondary code. The new configuration applies from the next cycle. With fastlock enabled and the gain bit at 1, `cp_code` equals the secondary code.
- R4: With fastlock disabled (bit 9 = 0), `cp_code` always equals the primary code. Gain-bit writes are still stored and can be read back.
- R5: In the manual mode the gain bit stays at 1, whatever strobes arrive, until software writes it to 0.
- R6: In the timed mode the gain bit is cleared at the clock edge that samples the (3 + 4 × timer code)-th `pd_tick` strobe counted after the gain bit was written as 1. `cp_code` returns to the primary code at the same time. Timeouts range from 3 to 63 strobes.
- R7: Writing the gain bit as 1 again while a timed interval is running restarts the count from zero.
- R8: While `tmr_pwr_dn` is 1 the timer is held at its load value. Strobes are not counted, and counting starts again from zero after release.
- R9: Disabling fastlock clears a running timer. After fastlock is enabled again, the full timeout is counted from zero.
- R10: Only cycles with `pd_tick` at 1 advance the timer. Other cycles leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_wr | input | 1 | One-cycle write strobe for the function latch |
| func_data | input | 24 | Function latch word (fields given in R3) |
| fb_wr | input | 1 | One-cycle write strobe for the feedback-counter latch |
| fb_gain | input | 1 | Gain bit value carried by a feedback-counter write |
| pd_tick | input | 1 | One-cycle strobe per phase-detector clock period |
| tmr_pwr_dn | input | 1 | Holds the timer at its load value while 1 |
| cp_code | output | 3 | Active charge-pump current code |
| gain_bit | output | 1 | Read-back of the stored gain bit |

## Verification
The assertions assume that `func_wr`, `fb_wr` and `pd_tick` are single-cycle strobes synchronous to `clk`. They also assume that `fb_gain` and `func_data` are valid whenever their strobe is high. The stimulus drives every input just after a falling edge and drops each strobe after one rising edge, so no strobe is seen twice. Register writes and timer strobes fall in separate cycles, so each expected timeout can be counted in whole strobes.

// File: rtl/fl_pkg.sv
`timescale 1ns/1ps
// Shared constants and the decoded configuration type for the fastlock
// current timer. Field positions are fixed by the latch word format.
package fl_pkg;
    localparam int CODE_W   = 3;
    localparam int TC_W     = 4;
    localparam int EN_BIT   = 9;
    localparam int MODE_BIT = 10;
    localparam int TC_LSB   = 11;
    localparam int PRI_LSB  = 15;
    localparam int SEC_LSB  = 18;
    localparam int CFG_TOP  = SEC_LSB + CODE_W - 1;

    typedef struct packed {
        logic              en;
        logic              timed;
        logic [TC_W-1:0]   tc;
        logic [CODE_W-1:0] pri;
        logic [CODE_W-1:0] sec;
    } fl_cfg_t;
endpackage

// File: rtl/fl_cfg_reg.sv
`timescale 1ns/1ps
// Configuration register: captures the function latch word on a write
// strobe and keeps the decoded fields. Assumes wr is a one-cycle strobe
// and that the word is at least CFG_TOP+1 bits wide.
module fl_cfg_reg
    import fl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_data,
    output fl_cfg_t           cfg
);
    localparam int SPARE_W = WORD_W - CFG_TOP - 1;

    logic unused_bits;
    generate
        if (SPARE_W > 0) begin : g_spare
            assign unused_bits = ^{wr_data[EN_BIT-1:0], wr_data[WORD_W-1:CFG_TOP+1]};
        end else begin : g_nospare
            assign unused_bits = ^wr_data[EN_BIT-1:0];
        end
    endgenerate

    // Load the decoded fields on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.en    <= wr_data[EN_BIT];
            cfg.timed <= wr_data[MODE_BIT];
            cfg.tc    <= wr_data[TC_LSB +: TC_W];
            cfg.pri   <= wr_data[PRI_LSB +: CODE_W];
            cfg.sec   <= wr_data[SEC_LSB +: CODE_W];
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg));
endmodule

// File: rtl/fl_timer.sv
`timescale 1ns/1ps
// Timeout counter for the timed fastlock mode. It counts tick strobes
// while run is high and raises expire on the strobe that completes
// 3 + 4*tc counts. Assumes tick is a one-cycle strobe. A dropped run or
// a restart forces the count back to its load value of zero.
module fl_timer
    import fl_pkg::*;
#(
    parameter int TCW = TC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic           tick,
    input  logic [TCW-1:0] tc,
    output logic           expire
);
    localparam int LIM_MAX = 3 + 4 * ((1 << TCW) - 1);
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Index of the final strobe of the interval (limit minus one).
    always_comb last = CNT_W'(tc) * CNT_W'(4) + CNT_W'(2);

    // Expiry is flagged on the strobe that completes the interval.
    always_comb expire = run && tick && !restart && (cnt >= last);

    // Count strobes, or return to the load value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> $stable(cnt));
    // R8
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIM_MAX - 1));
endmodule

// File: rtl/fl_cur_sel.sv
`timescale 1ns/1ps
// Current code selector: picks the secondary code while fastlock is
// enabled and the gain bit is set, otherwise the primary code. Purely
// combinational. Assumes its inputs come from registers.
module fl_cur_sel
    import fl_pkg::*;
(
    input  fl_cfg_t           cfg,
    input  logic              gain,
    output logic [CODE_W-1:0] code
);
    // Choose the active code.
    always_comb code = (cfg.en && gain) ? cfg.sec : cfg.pri;
endmodule

// File: rtl/fastlock_cp_timer.sv
`timescale 1ns/1ps
// Fastlock charge-pump current timer. It holds the configuration and the
// software-set gain bit. In the timed mode the gain bit is cleared once
// the programmed count of phase-detector strobes has elapsed. Assumes all
// write and tick inputs are one-cycle strobes synchronous to clk.
module fastlock_cp_timer
    import fl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_wr,
    input  logic [WORD_W-1:0] func_data,
    input  logic              fb_wr,
    input  logic              fb_gain,
    input  logic              pd_tick,
    input  logic              tmr_pwr_dn,
    output logic [CODE_W-1:0] cp_code,
    output logic              gain_bit
);
    fl_cfg_t cfg;
    logic    gain_q;
    logic    run;
    logic    restart;
    logic    expire;

    fl_cfg_reg #(.WORD_W(WORD_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (func_wr),
        .wr_data (func_data),
        .cfg     (cfg)
    );

    // Timer runs only in the enabled timed mode with the gain bit set.
    always_comb run     = cfg.en && cfg.timed && gain_q && !tmr_pwr_dn;
    always_comb restart = fb_wr && fb_gain;

    fl_timer #(.TCW(TC_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (pd_tick),
        .tc      (cfg.tc),
        .expire  (expire)
    );

    // Gain bit: a software write wins, otherwise expiry clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= 1'b0;
        end else if (fb_wr) begin
            gain_q <= fb_gain;
        end else if (expire) begin
            gain_q <= 1'b0;
        end
    end

    fl_cur_sel u_sel (
        .cfg  (cfg),
        .gain (gain_q),
        .code (cp_code)
    );

    always_comb gain_bit = gain_q;

    // R2
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_q) |-> $past(fb_wr && fb_gain));
    // R6
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gain_q) |-> ($past(fb_wr && !fb_gain) || $past(expire)));
    // R5
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !cfg.timed && gain_q && !fb_wr) |=> gain_q);
    // R4
    prim_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (cp_code == cfg.pri));
endmodule

// File: tb/test_fastlock_cp_timer.sv
`timescale 1ns/1ps
module test_fastlock_cp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_wr = 1'b0;
    logic [23:0] func_data = '0;
    logic        fb_wr = 1'b0;
    logic        fb_gain = 1'b0;
    logic        pd_tick = 1'b0;
    logic        tmr_pwr_dn = 1'b0;
    logic [2:0]  cp_code;
    logic        gain_bit;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    fastlock_cp_timer i_fastlock_cp_timer (
        .clk(clk), .rst_n(rst_n), .func_wr(func_wr), .func_data(func_data),
        .fb_wr(fb_wr), .fb_gain(fb_gain), .pd_tick(pd_tick),
        .tmr_pwr_dn(tmr_pwr_dn), .cp_code(cp_code), .gain_bit(gain_bit)
    );

    // Build a function latch word: en bit 9, mode bit 10, tc 14:11, pri 17:15, sec 20:18.
    function automatic logic [23:0] fword(input logic en, input logic timed,
                                          input logic [3:0] tc, input logic [2:0] pri,
                                          input logic [2:0] sec);
        logic [23:0] w;
        w = '0;
        w[9] = en;
        w[10] = timed;
        w[14:11] = tc;
        w[17:15] = pri;
        w[20:18] = sec;
        return w;
    endfunction

    // Monitor: pop one expectation per cycle and compare.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({cp_code, gain_bit} !== e) begin
                bad++;
                $display("FAIL %s: code=%0d gain=%0d expected code=%0d gain=%0d",
                         t, cp_code, gain_bit, e[3:1], e[0]);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the outcome expected after it.
    task automatic cyc(input logic fw, input logic [23:0] fd, input logic bw,
                       input logic bg, input logic tk, input logic pd,
                       input logic [2:0] ec, input logic eg, input string tag);
        @(negedge clk);
        func_wr = fw; func_data = fd; fb_wr = bw; fb_gain = bg;
        pd_tick = tk; tmr_pwr_dn = pd;
        @(posedge clk);
        #1;
        func_wr = 1'b0; fb_wr = 1'b0; pd_tick = 1'b0;
        exp_q.push_back({ec, eg});
        tag_q.push_back(tag);
    endtask

    task automatic cfg_w(input logic [23:0] w, input logic [2:0] ec, input logic eg,
                         input string tag);
        cyc(1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0, ec, eg, tag);
    endtask

    task automatic gain_w(input logic g, input logic [2:0] ec, input string tag);
        cyc(1'b0, '0, 1'b1, g, 1'b0, 1'b0, ec, g, tag);
    endtask

    task automatic ticks(input int n, input logic pd, input logic [2:0] ec,
                         input logic eg, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, pd, ec, eg, tag);
    endtask

    task automatic idles(input int n, input logic [2:0] ec, input logic eg,
                         input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, ec, eg, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idles(1, 3'd0, 1'b0, "R1");

        // Manual mode.
        cfg_w(fword(1, 0, 4'd0, 3'd2, 3'd5), 3'd2, 1'b0, "R3");
        gain_w(1'b1, 3'd5, "R2");
        ticks(80, 1'b0, 3'd5, 1'b1, "R5");
        gain_w(1'b0, 3'd2, "R2");

        // Timed mode, timer code 1 -> 7 strobes.
        cfg_w(fword(1, 1, 4'd1, 3'd2, 3'd5), 3'd2, 1'b0, "R3");
        gain_w(1'b1, 3'd5, "R3");
        ticks(6, 1'b0, 3'd5, 1'b1, "R6");
        ticks(1, 1'b0, 3'd2, 1'b0, "R6");

        // Cycles without a strobe do not count.
        gain_w(1'b1, 3'd5, "R10");
        idles(10, 3'd5, 1'b1, "R10");
        ticks(6, 1'b0, 3'd5, 1'b1, "R10");
        ticks(1, 1'b0, 3'd2, 1'b0, "R10");

        // Rewrite restarts.
        gain_w(1'b1, 3'd5, "R7");
        ticks(5, 1'b0, 3'd5, 1'b1, "R7");
        gain_w(1'b1, 3'd5, "R7");
        ticks(6, 1'b0, 3'd5, 1'b1, "R7");
        ticks(1, 1'b0, 3'd2, 1'b0, "R7");

        // Power-down holds the timer at load.
        gain_w(1'b1, 3'd5, "R8");
        ticks(4, 1'b0, 3'd5, 1'b1, "R8");
        ticks(10, 1'b1, 3'd5, 1'b1, "R8");
        ticks(6, 1'b0, 3'd5, 1'b1, "R8");
        ticks(1, 1'b0, 3'd2, 1'b0, "R8");

        // Disable clears the timer; gain bit stays stored.
        gain_w(1'b1, 3'd5, "R9");
        ticks(4, 1'b0, 3'd5, 1'b1, "R9");
        cfg_w(fword(0, 1, 4'd1, 3'd2, 3'd5), 3'd2, 1'b1, "R4");
        ticks(10, 1'b0, 3'd2, 1'b1, "R4");
        cfg_w(fword(1, 1, 4'd1, 3'd2, 3'd5), 3'd5, 1'b1, "R9");
        ticks(6, 1'b0, 3'd5, 1'b1, "R9");
        ticks(1, 1'b0, 3'd2, 1'b0, "R9");

        // Disabled: writes stored, primary code kept.
        cfg_w(fword(0, 0, 4'd0, 3'd6, 3'd1), 3'd6, 1'b0, "R4");
        gain_w(1'b1, 3'd6, "R4");
        gain_w(1'b0, 3'd6, "R4");

        // Shortest and longest timeouts.
        cfg_w(fword(1, 1, 4'd0, 3'd6, 3'd1), 3'd6, 1'b0, "R3");
        gain_w(1'b1, 3'd1, "R6");
        ticks(2, 1'b0, 3'd1, 1'b1, "R6");
        ticks(1, 1'b0, 3'd6, 1'b0, "R6");
        cfg_w(fword(1, 1, 4'd15, 3'd6, 3'd1), 3'd6, 1'b0, "R3");
        gain_w(1'b1, 3'd1, "R6");
        ticks(62, 1'b0, 3'd1, 1'b1, "R6");
        ticks(1, 1'b0, 3'd6, 1'b0, "R6");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule